// File: doc/BRIEF.md
# Video frame trigger sequencer

This block sequences triggered frame acquisition in a frame grabber that follows the field timing of a camera. A rising edge on the trigger input arms an acquisition cycle. The cycle starts at a point in vertical blanking. That point depends on whether the strobe is enabled. The cycle then marks one or two active regions as memory-load windows and returns to the armed state. An optional strobe pulse one line long can be placed a programmable number of lines after vertical sync, so a light source can be timed to the acquired frame.

Three configuration inputs select how the cycle behaves. Stored-trigger mode queues one trigger that arrives while a cycle is running, so that cycles can follow each other back to back. Skip mode discards the first field after the cycle starts. With the strobe disabled, vertical sync is ignored and any trigger inside blanking catches the next field. The configuration inputs are assumed stable while a cycle is in progress.

Top module: `vft_seq`

## Requirements
- R1: During and after a synchronous active-low reset, `armed`=1, `in_cycle`=0, `mem_load`=0 and the strobe is inactive (`strobe_out` equals `strobe_invert`). Only a 0-to-1 transition of `trig_in` counts as a trigger, and the edge history is cleared by reset.
- R2: With `strobe_en`=1, a trigger sampled while armed begins a cycle at the next clock on which `vsync` is sampled high, provided that clock comes after the trigger clock. A trigger sampled on the same clock as `vsync`, or after it, waits for the following field's `vsync`.
- R3: With `strobe_en`=0, `vsync` has no effect. A trigger sampled while `vblank`=1 begins a cycle on the next clock. A trigger sampled while `vblank`=0 waits and begins a cycle on the clock after `vblank` is next sampled high.
- R4: When a cycle begins from the armed state, `armed` falls and `in_cycle` rises on the same clock.
- R5: With `stored_mode`=0, triggers sampled while a cycle is pending or running have no effect.
- R6: With `stored_mode`=1, a trigger during a running cycle is held as at most one pending event. When the cycle ends, a new cycle begins at once with `in_cycle` staying high, and further triggers are dropped.
- R7: With `skip_mode`=1, the first active region after the cycle begins is not loaded, and loading starts with the next one.
- R8: `mem_load` is high exactly on the clocks that follow a sample of `vblank`=0 inside an acquired field. A cycle acquires one field when `two_fields`=0 and two fields when it is 1.
- R9: At the first `vsync` of a cycle with `strobe_en`=1, a line counter is loaded with `strobe_dly`. The counter decrements on each `hsync`. At the `hsync` that finds it at zero, the strobe turns on, and it stays on until the next `hsync`: exactly one line. A delay of 0 fires on the first line after `vsync`.
- R10: `strobe_out` is the active strobe state XORed with `strobe_invert`, so `strobe_invert`=1 gives an active-low pulse.
- R11: `in_cycle` clears on the clock after `vblank` is sampled high at the end of the last acquired field. If no trigger is pending, `armed` is set on that clock.
- R12: Asserting reset in the middle of a cycle abandons it and returns the block to the armed state with no load or strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vblank | input | 1 | High during vertical blanking |
| vsync | input | 1 | Single-clock vertical sync pulse inside blanking |
| hsync | input | 1 | Single-clock line tick |
| trig_in | input | 1 | Trigger request, rising edge detected |
| strobe_en | input | 1 | Enable strobe and vsync-qualified start |
| stored_mode | input | 1 | Queue one trigger during a running cycle |
| skip_mode | input | 1 | Skip the first field after cycle start |
| strobe_invert | input | 1 | Invert strobe output polarity |
| two_fields | input | 1 | Acquire two fields instead of one |
| strobe_dly | input | DLY_W | Strobe delay in lines after vsync |
| armed | output | 1 | Trigger-enable status |
| in_cycle | output | 1 | Trigger-cycle status |
| mem_load | output | 1 | Memory-load enable for acquired fields |
| strobe_out | output | 1 | Strobe pulse, polarity per strobe_invert |

## Verification
The assertions check on every cycle that load windows appear only inside a cycle and after a sampled active line. They also check that `armed` falls exactly when `in_cycle` rises, that the strobe switches only on line ticks, and that the cycle flag drops only at the start of blanking with the block armed again. The bench's scenarios are needed for the rest. These are the start point chosen for triggers placed before, on and after vsync, with and without the strobe; triggers ignored or queued during a cycle; skipped fields; two-field loads; the strobe position for delays of zero and two lines; and a reset that abandons a running cycle.

// File: rtl/vft_pkg.sv
// Package: shared state encoding for the video frame trigger sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package vft_pkg;

    // Sequencer phases: armed, trigger seen but start not reached,
    // cycle waiting for active video, skipping a field, loading a field.
    typedef enum logic [2:0] {
        ST_ARMED = 3'd0,
        ST_PEND  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SKIP  = 3'd3,
        ST_LOAD  = 3'd4
    } vft_state_t;

endpackage

// File: rtl/vft_edge.sv
// Module: single-bit edge detector.
// Produces a one-clock pulse on the chosen transition of din, in the same
// clock in which the new level is sampled. The history flop clears on reset,
// so a level already high when reset is released counts as a rising edge.
module vft_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);

    logic hist_q;

    // Remember the previous sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= din;
    end

    if (RISING) begin : g_rise
        assign pulse = din & ~hist_q;
    end else begin : g_fall
        assign pulse = ~din & hist_q;
    end

endmodule

// File: rtl/vft_ctrl.sv
// Module: acquisition cycle controller.
// Moves from armed through start qualification, optional field skip and
// one or two load fields, then back to armed or straight into a queued cycle.
// Assumes vsync pulses only while vblank is high, and that the configuration
// inputs stay stable during a cycle. Field boundaries are taken from the
// vblank level: active region starts when vblank is sampled low and ends when
// it is sampled high again.
module vft_ctrl
    import vft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_rise,
    input  logic       vblank,
    input  logic       vsync,
    input  logic       strobe_en,
    input  logic       stored_mode,
    input  logic       skip_mode,
    input  logic       two_fields,
    output vft_state_t state,
    output logic       cyc_start
);

    vft_state_t st_q, st_n;
    logic       pend_q, pend_n;
    logic       skip_q, skip_n;
    logic       half_q, half_n;
    logic       running;
    logic       last_field;

    assign running    = (st_q == ST_WAIT) || (st_q == ST_SKIP) || (st_q == ST_LOAD);
    assign last_field = !two_fields || half_q;

    // Next-state and bookkeeping for pending trigger, skip and field count.
    always_comb begin
        st_n      = st_q;
        pend_n    = pend_q;
        skip_n    = skip_q;
        half_n    = half_q;
        cyc_start = 1'b0;
        if (running && trig_rise && stored_mode) pend_n = 1'b1;
        case (st_q)
            ST_ARMED: begin
                if (trig_rise) begin
                    if (!strobe_en && vblank) cyc_start = 1'b1;
                    else                      st_n = ST_PEND;
                end
            end
            ST_PEND: begin
                if (strobe_en ? vsync : vblank) cyc_start = 1'b1;
            end
            ST_WAIT: begin
                if (!vblank) st_n = skip_q ? ST_SKIP : ST_LOAD;
            end
            ST_SKIP: begin
                if (vblank) begin
                    st_n   = ST_WAIT;
                    skip_n = 1'b0;
                end
            end
            ST_LOAD: begin
                if (vblank) begin
                    if (!last_field) begin
                        half_n = 1'b1;
                        st_n   = ST_WAIT;
                    end else if (pend_n) begin
                        cyc_start = 1'b1;
                    end else begin
                        st_n = ST_ARMED;
                    end
                end
            end
            default: st_n = ST_ARMED;
        endcase
        if (cyc_start) begin
            st_n   = ST_WAIT;
            pend_n = 1'b0;
            skip_n = skip_mode;
            half_n = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_ARMED;
            pend_q <= 1'b0;
            skip_q <= 1'b0;
            half_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            skip_q <= skip_n;
            half_q <= half_n;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/vft_strobe.sv
// Module: strobe line-delay timer.
// A cycle that starts with the strobe enabled owes one strobe. The first vsync
// seen while owed (or on the start clock itself) loads the delay, which then
// counts hsync ticks. The tick that finds zero turns the strobe on for one line.
// The output polarity is applied here.
module vft_strobe #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             strobe_en,
    input  logic             vsync,
    input  logic             hsync,
    input  logic             strobe_invert,
    input  logic [DLY_W-1:0] strobe_dly,
    output logic             strobe_out
);

    logic             owed_q;
    logic             run_q;
    logic             act_q;
    logic [DLY_W-1:0] cnt_q;
    logic             load;

    assign load = vsync && strobe_en && (owed_q || cyc_start);

    // Delay counter, owed flag and one-line strobe state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= 1'b0;
            run_q  <= 1'b0;
            act_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (hsync && act_q) act_q <= 1'b0;
            if (load) begin
                cnt_q  <= strobe_dly;
                run_q  <= 1'b1;
                owed_q <= 1'b0;
            end else begin
                if (cyc_start && strobe_en) owed_q <= 1'b1;
                if (hsync && run_q) begin
                    if (cnt_q == '0) begin
                        act_q <= 1'b1;
                        run_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    assign strobe_out = act_q ^ strobe_invert;

endmodule

// File: rtl/vft_seq.sv
// Module: video frame trigger sequencer (top).
// Ties the trigger edge detector, the cycle controller and the strobe timer
// together and decodes the status flags and the load enable from the
// controller state. All inputs are synchronous to clk.
module vft_seq
    import vft_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vblank,
    input  logic             vsync,
    input  logic             hsync,
    input  logic             trig_in,
    input  logic             strobe_en,
    input  logic             stored_mode,
    input  logic             skip_mode,
    input  logic             strobe_invert,
    input  logic             two_fields,
    input  logic [DLY_W-1:0] strobe_dly,
    output logic             armed,
    output logic             in_cycle,
    output logic             mem_load,
    output logic             strobe_out
);

    vft_state_t state;
    logic       trig_rise;
    logic       cyc_start;

    vft_edge #(.RISING(1'b1)) u_trig_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_in),
        .pulse (trig_rise)
    );

    vft_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_rise   (trig_rise),
        .vblank      (vblank),
        .vsync       (vsync),
        .strobe_en   (strobe_en),
        .stored_mode (stored_mode),
        .skip_mode   (skip_mode),
        .two_fields  (two_fields),
        .state       (state),
        .cyc_start   (cyc_start)
    );

    vft_strobe #(.DLY_W(DLY_W)) u_strobe (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start     (cyc_start),
        .strobe_en     (strobe_en),
        .vsync         (vsync),
        .hsync         (hsync),
        .strobe_invert (strobe_invert),
        .strobe_dly    (strobe_dly),
        .strobe_out    (strobe_out)
    );

    // Status and load decode from the controller state.
    always_comb begin
        armed    = (state == ST_ARMED) || (state == ST_PEND);
        in_cycle = (state == ST_WAIT) || (state == ST_SKIP) || (state == ST_LOAD);
        mem_load = (state == ST_LOAD);
    end

endmodule

// File: rtl/vft_seq_chk.sv
// Module: protocol checker for vft_seq, attached by bind.
// Checks are disabled in the reset clock and the clock after it, so that
// history taken across reset never triggers a property.
module vft_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic vblank,
    input logic hsync,
    input logic strobe_invert,
    input logic armed,
    input logic in_cycle,
    input logic mem_load,
    input logic strobe_out
);

    logic rst_q;
    logic strobe_on;

    // Delayed reset, keeps checks off one clock after release.
    always_ff @(posedge clk) rst_q <= rst_n;

    assign strobe_on = strobe_out ^ strobe_invert;

    // R8: loading only inside a cycle and after a sampled active line.
    a_r8_load_window: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        mem_load |-> (in_cycle && !$past(vblank)));

    // R4: leaving the armed state always starts a cycle on the same clock.
    a_r4_start_flags: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        $fell(armed) |-> $rose(in_cycle));

    // R11: the cycle flag drops only at blanking, with the block armed again.
    a_r11_end_armed: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        $fell(in_cycle) |-> (armed && $past(vblank)));

    // R9: the strobe turns on only at a line tick.
    a_r9_on_at_line: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        $rose(strobe_on) |-> $past(hsync));

    // R9: the strobe turns off only at a line tick.
    a_r9_off_at_line: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        $fell(strobe_on) |-> $past(hsync));

endmodule

bind vft_seq vft_seq_chk u_vft_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vblank        (vblank),
    .hsync         (hsync),
    .strobe_invert (strobe_invert),
    .armed         (armed),
    .in_cycle      (in_cycle),
    .mem_load      (mem_load),
    .strobe_out    (strobe_out)
);

// File: tb/tb_vft_seq.sv
// Bench for vft_seq: a behavioural reference model is stepped on every
// rising edge and all outputs are compared on every falling edge. Directed
// checks on top of that confirm start points, load counts and strobe width.
module tb_vft_seq;

    localparam int LINE_CLK  = 8;
    localparam int FIELD_LN  = 20;
    localparam int BLANK_LN  = 6;
    localparam int VS_LN     = 3;
    localparam int FIELD_CLK = LINE_CLK * FIELD_LN;
    localparam int ACT_CLK   = LINE_CLK * (FIELD_LN - BLANK_LN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic strobe_en = 1'b1, stored_mode = 1'b0, skip_mode = 1'b0;
    logic strobe_invert = 1'b0, two_fields = 1'b0;
    logic [7:0] strobe_dly = 8'd2;
    logic vblank, vsync, hsync;
    logic armed, in_cycle, mem_load, strobe_out;

    int pos = 0;
    int vectors = 0;
    int miscmp = 0;
    int load_cnt = 0;
    int strobe_cnt = 0;
    bit started = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    // Video timing source.
    always @(posedge clk) pos <= (pos == FIELD_CLK - 1) ? 0 : pos + 1;
    assign hsync  = (pos % LINE_CLK) == 0;
    assign vsync  = pos == VS_LN * LINE_CLK;
    assign vblank = pos < BLANK_LN * LINE_CLK;

    vft_seq #(.DLY_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .vblank(vblank), .vsync(vsync), .hsync(hsync),
        .trig_in(trig_in), .strobe_en(strobe_en), .stored_mode(stored_mode),
        .skip_mode(skip_mode), .strobe_invert(strobe_invert), .two_fields(two_fields),
        .strobe_dly(strobe_dly), .armed(armed), .in_cycle(in_cycle),
        .mem_load(mem_load), .strobe_out(strobe_out)
    );

    // Reference model: 0 armed, 1 pending, 2 waiting, 3 skipping, 4 loading.
    int  m_mode = 0, m_done = 0, m_cnt = 0;
    bit  m_tq = 0, m_q = 0, m_skip = 0, m_owe = 0, m_run = 0, m_act = 0;

    always @(posedge clk) begin
        bit rise, go, ld;
        int need;
        if (!rst_n) begin
            m_mode = 0; m_done = 0; m_cnt = 0; m_tq = 0; m_q = 0;
            m_skip = 0; m_owe = 0; m_run = 0; m_act = 0;
            started = 1;
        end else begin
            rise = trig_in && !m_tq;
            m_tq = trig_in;
            go = 0;
            need = two_fields ? 2 : 1;
            if (m_mode >= 2 && rise && stored_mode) m_q = 1;
            if (m_mode == 0) begin
                if (rise) begin
                    if (!strobe_en && vblank) go = 1; else m_mode = 1;
                end
            end else if (m_mode == 1) begin
                if (strobe_en ? vsync : vblank) go = 1;
            end else if (m_mode == 2) begin
                if (!vblank) m_mode = m_skip ? 3 : 4;
            end else if (m_mode == 3) begin
                if (vblank) begin m_mode = 2; m_skip = 0; end
            end else begin
                if (vblank) begin
                    m_done++;
                    if (m_done < need) m_mode = 2;
                    else if (m_q) go = 1;
                    else m_mode = 0;
                end
            end
            if (go) begin m_mode = 2; m_q = 0; m_skip = skip_mode; m_done = 0; end
            ld = vsync && strobe_en && (m_owe || go);
            if (hsync && m_act) m_act = 0;
            if (ld) begin m_cnt = strobe_dly; m_run = 1; m_owe = 0; end
            else begin
                if (go && strobe_en) m_owe = 1;
                if (hsync && m_run) begin
                    if (m_cnt == 0) begin m_act = 1; m_run = 0; end
                    else m_cnt--;
                end
            end
        end
    end

    // Per-clock comparison against the model and activity counters.
    always @(negedge clk) begin
        logic [3:0] act, exp;
        if (started) begin
            act = {armed, in_cycle, mem_load, strobe_out};
            exp = {m_mode <= 1, m_mode >= 2, m_mode == 4, m_act ^ strobe_invert};
            vectors++;
            if (act !== exp) begin
                miscmp++;
                $display("FAIL %s {armed,in_cycle,mem_load,strobe} act=%b exp=%b pos=%0d",
                         cur_req, act, exp, pos);
            end
            if (mem_load === 1'b1) load_cnt++;
            if ((strobe_out ^ strobe_invert) === 1'b1) strobe_cnt++;
        end
    end

    task automatic check(input string req, input string what, input int a, input int e);
        vectors++;
        if (a !== e) begin
            miscmp++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, a, e);
        end
    endtask

    task automatic wait_pos(input int p);
        @(negedge clk);
        while (pos != p) @(negedge clk);
    endtask

    task automatic wait_fields(input int n);
        for (int i = 0; i < n; i++) wait_pos(0);
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic clear_counts();
        load_cnt = 0;
        strobe_cnt = 0;
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (60000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (4) @(negedge clk);
        check("R1", "armed in reset", armed, 1);
        check("R1", "in_cycle in reset", in_cycle, 0);
        rst_n = 1'b1;
        wait_fields(1);

        // R2 R4 R8 R9 R11: strobe enabled, trigger before vsync, delay 2.
        cur_req = "R2";
        clear_counts();
        wait_pos(10); pulse_trig();
        wait_pos(VS_LN * LINE_CLK + 2);
        check("R4", "in_cycle after vsync start", in_cycle, 1);
        check("R4", "armed after vsync start", armed, 0);
        wait_fields(2);
        check("R8", "single field load cycles", load_cnt, ACT_CLK);
        check("R9", "strobe width delay 2", strobe_cnt, LINE_CLK);
        check("R11", "armed after cycle", armed, 1);

        // R2: trigger on the vsync clock waits one field.
        clear_counts();
        wait_pos(VS_LN * LINE_CLK); pulse_trig();
        wait_pos(40);
        check("R2", "no start on late trigger", in_cycle, 0);
        wait_fields(3);
        check("R2", "late trigger loads next field", load_cnt, ACT_CLK);

        // R3: strobe disabled, trigger in blanking and in active video.
        cur_req = "R3";
        strobe_en = 1'b0;
        clear_counts();
        wait_pos(40); pulse_trig();
        @(negedge clk);
        check("R3", "start inside blanking", in_cycle, 1);
        wait_fields(1);
        wait_pos(100); pulse_trig();
        wait_pos(110);
        check("R3", "active trigger misses field", in_cycle, 0);
        wait_fields(3);
        check("R3", "two single-field cycles", load_cnt, 2 * ACT_CLK);
        check("R9", "no strobe when disabled", strobe_cnt, 0);

        // R5: default mode ignores triggers during a cycle.
        cur_req = "R5";
        strobe_en = 1'b1;
        clear_counts();
        wait_pos(10); pulse_trig();
        wait_pos(100); pulse_trig();
        wait_pos(10);
        check("R5", "in_cycle after ignored trigger", in_cycle, 0);
        wait_fields(3);
        check("R5", "only one field loaded", load_cnt, ACT_CLK);

        // R6: stored mode queues exactly one trigger.
        cur_req = "R6";
        stored_mode = 1'b1;
        clear_counts();
        wait_pos(10); pulse_trig();
        wait_pos(80); pulse_trig();
        wait_pos(100); pulse_trig();
        wait_pos(2);
        check("R6", "queued cycle keeps in_cycle", in_cycle, 1);
        wait_fields(3);
        check("R6", "two cycles from three triggers", load_cnt, 2 * ACT_CLK);
        check("R6", "one strobe per cycle", strobe_cnt, 2 * LINE_CLK);
        stored_mode = 1'b0;

        // R7: skip the first field.
        cur_req = "R7";
        skip_mode = 1'b1;
        clear_counts();
        wait_pos(10); pulse_trig();
        wait_pos(100);
        check("R7", "no load in skipped field", mem_load, 0);
        wait_fields(1);
        wait_pos(100);
        check("R7", "load in following field", mem_load, 1);
        wait_fields(2);
        check("R7", "one field after skip", load_cnt, ACT_CLK);
        skip_mode = 1'b0;

        // R8: two-field acquisition.
        cur_req = "R8";
        two_fields = 1'b1;
        clear_counts();
        wait_pos(10); pulse_trig();
        wait_fields(4);
        check("R8", "two field load cycles", load_cnt, 2 * ACT_CLK);
        two_fields = 1'b0;

        // R9 R10: zero delay, inverted polarity.
        cur_req = "R10";
        strobe_dly = 8'd0;
        strobe_invert = 1'b1;
        @(negedge clk);
        check("R10", "idle level inverted", strobe_out, 1);
        clear_counts();
        wait_pos(10); pulse_trig();
        wait_pos((VS_LN + 1) * LINE_CLK + 2);
        check("R9", "zero delay fires first line", strobe_out, 0);
        wait_fields(3);
        check("R9", "strobe width delay 0", strobe_cnt, LINE_CLK);
        strobe_invert = 1'b0;
        strobe_dly = 8'd2;

        // R12: reset in the middle of a cycle.
        cur_req = "R12";
        wait_pos(10); pulse_trig();
        wait_pos(90);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "armed after mid-cycle reset", armed, 1);
        check("R12", "no load after mid-cycle reset", mem_load, 0);
        wait_fields(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule